// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block follows a table of region descriptors held in memory and turns it into a stream of transfer segments, each an address and a byte count, for one bus-master disk DMA channel. A start pulse latches the table base and the number of bytes the drive side wants moved. The walker then fetches descriptors one at a time over a valid/ready read port, with each fetch answered by one 64-bit beat. It hands out segments that never run past the current region or past the bytes still owed to the drive.

A run ends in one of two ways. The request is filled, which is a complete finish. The table runs out first, which is a short finish. The table runs out when the descriptor flagged as final has been used up, or when the fetch pointer has moved a full 4096-byte page beyond the base. The page limit guards against a table that never sets the final flag. Moving the data and talking to the drive belong to other blocks.

Top module: `prd_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `done`, `mem_req_valid` and `chunk_valid` are all low.
- R2: A descriptor beat carries the region address in bits 31:0 and the size word in bits 63:32. The region length is the size word ANDed with 0xFFFE, so size bit 0 has no effect.
- R3: A masked length of zero stands for a 65536-byte region.
- R4: Size-word bit 31 marks the final descriptor. Once that region is used up, no further descriptor is fetched.
- R5: The first fetch reads address `tbl_base`. Each later fetch reads 8 bytes past the one before it.
- R6: A new descriptor is fetched only when the current region length is zero. Each segment length is the smaller of the bytes still requested and the bytes left in the region. The segment address is the region address advanced by what earlier segments took from that region.
- R7: No fetch is issued once the pointer is 4096 or more bytes past the base. The walk then ends as a short finish.
- R8: `done` pulses for one cycle at the end of a run. `done_ok` is 1 with it when every requested byte was segmented, and 0 when the table ran out first.
- R9: A pending fetch request or segment keeps its valid, address and length unchanged until accepted.
- R10: A `start` pulse while `busy` is high is ignored. The run carries on with its original base and request.
- R11: A start with a request of zero bytes finishes complete without any fetch or segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk, honoured only while not busy |
| tbl_base | input | 32 | Table base address, 8-byte aligned |
| req_bytes | input | LEN_W | Bytes the drive side asks for |
| mem_req_valid | output | 1 | Descriptor fetch request |
| mem_req_ready | input | 1 | Fetch request accepted |
| mem_req_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor beat present |
| mem_rsp_data | input | 64 | Descriptor beat |
| chunk_valid | output | 1 | Segment offered |
| chunk_ready | input | 1 | Segment accepted |
| chunk_addr | output | 32 | Segment start address |
| chunk_len | output | 17 | Segment byte count |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| done_ok | output | 1 | With done: request fully segmented |

## Verification
The walker is driven with tables that end exactly on the request, tables longer than the request, and tables shorter than it. These tell a complete finish from a short one and show that no descriptor is fetched past what is needed. Size words with bit 0 set and a zero length check the length decoding. A 512-entry table with no final flag tells the page limit apart from the final-flag stop. A stalling segment consumer and a start pulse in the middle of a run check hold behaviour and that a busy walker ignores the pulse. Every segment is compared with a minimum computed in the bench, and every fetch address with the base plus eight times the fetch count.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int ADDR_W  = 32;
  localparam int RLEN_W  = 17;
  localparam int BEAT_W  = 64;
  localparam int DESC_BYTES = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_WAIT,
    ST_ISSUE,
    ST_DONE
  } walk_st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [RLEN_W-1:0] len;
    logic              last;
  } region_t;
endpackage

// File: rtl/prd_desc_decode.sv
module prd_desc_decode
  import prd_pkg::*;
(
  input  logic [BEAT_W-1:0] beat,
  output region_t           rgn
);
  logic [31:0] size_w;
  logic [15:0] masked;
  logic        unused_bits;

  assign size_w      = beat[63:32];
  assign masked      = {size_w[15:1], 1'b0};
  assign unused_bits = ^{size_w[30:16], size_w[0]};

  always_comb begin
    rgn.addr = beat[31:0];
    rgn.last = size_w[31];
    if (masked == 16'h0) rgn.len = 17'h1_0000;
    else                 rgn.len = {1'b0, masked};
  end
endmodule

// File: rtl/prd_chunk_sel.sv
module prd_chunk_sel
  import prd_pkg::*;
#(
  parameter int LEN_W = 20
) (
  input  logic [LEN_W-1:0]  remain,
  input  logic [RLEN_W-1:0] rgn_len,
  output logic [RLEN_W-1:0] len
);
  localparam int CMP_W = (LEN_W > RLEN_W) ? LEN_W : RLEN_W;

  logic [CMP_W-1:0] rem_x;
  logic [CMP_W-1:0] rgn_x;

  assign rem_x = CMP_W'(remain);
  assign rgn_x = CMP_W'(rgn_len);
  assign len   = (rem_x < rgn_x) ? RLEN_W'(rem_x) : rgn_len;
endmodule

// File: rtl/prd_walker.sv
module prd_walker
  import prd_pkg::*;
#(
  parameter int LEN_W      = 20,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       tbl_base,
  input  logic [LEN_W-1:0]  req_bytes,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              chunk_valid,
  input  logic              chunk_ready,
  output logic [31:0]       chunk_addr,
  output logic [16:0]       chunk_len,
  output logic              busy,
  output logic              done,
  output logic              done_ok
);
  localparam int CMP_W = (LEN_W > RLEN_W) ? LEN_W : RLEN_W;
  localparam logic [ADDR_W-1:0] PAGE_LIM = ADDR_W'(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(DESC_BYTES);

  walk_st_e          st_q, st_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] raddr_q, raddr_d;
  logic [RLEN_W-1:0] rlen_q, rlen_d;
  logic              rlast_q, rlast_d;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic              ok_q, ok_d;

  region_t           fetched;
  logic [RLEN_W-1:0] seg_len;
  logic              can_start;
  logic              table_end;
  logic              en;

  prd_desc_decode u_dec (
    .beat (mem_rsp_data),
    .rgn  (fetched)
  );

  prd_chunk_sel #(.LEN_W(LEN_W)) u_sel (
    .remain  (remain_q),
    .rgn_len (rlen_q),
    .len     (seg_len)
  );

  assign can_start = start && ((st_q == ST_IDLE) || (st_q == ST_DONE));
  assign table_end = rlast_q || ((ptr_q - base_q) >= PAGE_LIM);

  always_comb begin
    st_d     = st_q;
    base_d   = base_q;
    ptr_d    = ptr_q;
    raddr_d  = raddr_q;
    rlen_d   = rlen_q;
    rlast_d  = rlast_q;
    remain_d = remain_q;
    ok_d     = ok_q;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        st_d = ST_IDLE;
        if (can_start) begin
          base_d   = tbl_base;
          ptr_d    = tbl_base;
          raddr_d  = '0;
          rlen_d   = '0;
          rlast_d  = 1'b0;
          remain_d = req_bytes;
          ok_d     = 1'b0;
          st_d     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (remain_q == '0) begin
          ok_d = 1'b1;
          st_d = ST_DONE;
        end else if (rlen_q == '0) begin
          if (table_end) begin
            ok_d = 1'b0;
            st_d = ST_DONE;
          end else begin
            st_d = ST_FETCH;
          end
        end else begin
          st_d = ST_ISSUE;
        end
      end
      ST_FETCH: begin
        if (mem_req_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          raddr_d = fetched.addr;
          rlen_d  = fetched.len;
          rlast_d = fetched.last;
          ptr_d   = ptr_q + STEP;
          st_d    = ST_CHECK;
        end
      end
      ST_ISSUE: begin
        if (chunk_ready) begin
          raddr_d  = raddr_q + ADDR_W'(seg_len);
          rlen_d   = rlen_q - seg_len;
          remain_d = LEN_W'(CMP_W'(remain_q) - CMP_W'(seg_len));
          st_d     = ST_CHECK;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign en = (st_q != ST_IDLE) || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      base_q   <= '0;
      ptr_q    <= '0;
      raddr_q  <= '0;
      rlen_q   <= '0;
      rlast_q  <= 1'b0;
      remain_q <= '0;
      ok_q     <= 1'b0;
    end else if (en) begin
      st_q     <= st_d;
      base_q   <= base_d;
      ptr_q    <= ptr_d;
      raddr_q  <= raddr_d;
      rlen_q   <= rlen_d;
      rlast_q  <= rlast_d;
      remain_q <= remain_d;
      ok_q     <= ok_d;
    end
  end

  assign mem_req_valid = (st_q == ST_FETCH);
  assign mem_req_addr  = ptr_q;
  assign chunk_valid   = (st_q == ST_ISSUE);
  assign chunk_addr    = raddr_q;
  assign chunk_len     = seg_len;
  assign busy          = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done          = (st_q == ST_DONE);
  assign done_ok       = done && ok_q;

  // R6: a segment is non-empty and fits both the region and the request
  a_r6_seg_bound: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> (chunk_len != '0) && (chunk_len <= rlen_q) &&
                    (CMP_W'(chunk_len) <= CMP_W'(remain_q)));

  a_r9_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));

  a_r9_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && !chunk_ready) |=>
      chunk_valid && $stable(chunk_addr) && $stable(chunk_len));

  a_r7_page_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ((mem_req_addr - base_q) < PAGE_LIM));

  a_r4_no_fetch_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rlast_q);

  a_r10_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(base_q) && $stable(remain_q) || !busy);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/prd_walker_tb_top.sv
`timescale 1ns/1ps
module prd_walker_tb_top;
  localparam int LEN_W = 20;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [31:0]       tbl_base;
  logic [LEN_W-1:0]  req_bytes;
  logic              mem_req_valid;
  logic              mem_req_ready;
  logic [31:0]       mem_req_addr;
  logic              mem_rsp_valid;
  logic [63:0]       mem_rsp_data;
  logic              chunk_valid;
  logic              chunk_ready;
  logic [31:0]       chunk_addr;
  logic [16:0]       chunk_len;
  logic              busy;
  logic              done;
  logic              done_ok;

  prd_walker #(.LEN_W(LEN_W), .PAGE_BYTES(4096)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_base(tbl_base),
    .req_bytes(req_bytes), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
    .chunk_addr(chunk_addr), .chunk_len(chunk_len), .busy(busy),
    .done(done), .done_ok(done_ok)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [19:0] req;
    logic [9:0]  ndesc;
    logic [31:0] size;
    logic        lastmark;
    logic        stall;
    logic [9:0]  exp_fetch;
    logic [19:0] exp_bytes;
    logic        exp_ok;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [0:NV-1] = '{
    '{20'd100,     10'd1,   32'h0000_0100, 1'b1, 1'b0, 10'd1,   20'd100,     1'b1}, // R6 split
    '{20'h00300,   10'd3,   32'h0000_0101, 1'b1, 1'b0, 10'd3,   20'h00300,   1'b1}, // R2 bit0
    '{20'h00400,   10'd2,   32'h0000_0100, 1'b1, 1'b0, 10'd2,   20'h00200,   1'b0}, // R4 short
    '{20'h20000,   10'd2,   32'h0000_0000, 1'b1, 1'b0, 10'd2,   20'h20000,   1'b1}, // R3 64K
    '{20'h18000,   10'd3,   32'h0000_0000, 1'b1, 1'b0, 10'd2,   20'h18000,   1'b1}, // R6 no extra fetch
    '{20'hFFFFF,   10'd512, 32'h0000_0002, 1'b0, 1'b0, 10'd512, 20'd1024,    1'b0}, // R7 page
    '{20'd10,      10'd1,   32'h0000_0006, 1'b1, 1'b0, 10'd1,   20'd6,       1'b0}, // R8 short
    '{20'h00250,   10'd3,   32'h0000_0100, 1'b1, 1'b1, 10'd3,   20'h00250,   1'b1}, // R9 stall
    '{20'd0,       10'd1,   32'h0000_0100, 1'b1, 1'b0, 10'd0,   20'd0,       1'b1}  // R11 zero
  };

  logic [63:0] desc_tbl [0:511];
  logic [31:0] tb_base;
  int          fetch_cnt;
  int          fetch_err;
  int          seg_err;
  int          seg_cnt;
  logic [19:0] req_left;
  logic [19:0] bytes_sum;
  logic        stall_mode;
  int          n_checks;
  int          n_fail;
  int          cyc;
  logic        finished;

  function automatic logic [31:0] rgn_addr_of(input int idx);
    return 32'h4000_0010 + 32'(idx) * 32'h0002_0000;
  endfunction

  function automatic logic [19:0] dec_len(input logic [31:0] sz);
    logic [15:0] m;
    m = sz[15:0] & 16'hFFFE;
    return (m == 16'h0) ? 20'h10000 : {4'h0, m};
  endfunction

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // descriptor memory responder
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      if (mem_req_valid) begin
        logic [31:0] a;
        logic [31:0] idx;
        a = mem_req_addr;
        if (a != tb_base + 32'(fetch_cnt) * 32'd8) fetch_err++;
        mem_req_ready = 1'b1;
        fetch_cnt++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        idx = (a - tb_base) >> 3;
        mem_rsp_valid = 1'b1;
        if (idx < 32'd512) mem_rsp_data = desc_tbl[idx[8:0]];
        else begin
          mem_rsp_data = 64'h0000_0004_0000_0000;
          fetch_err++;
        end
      end
    end
  end

  // segment consumer
  initial begin
    chunk_ready = 1'b1;
    forever begin
      @(negedge clk);
      chunk_ready = stall_mode ? ~chunk_ready : 1'b1;
      if (chunk_valid && chunk_ready) begin
        logic [19:0] rl;
        logic [19:0] el;
        rl = dec_len(desc_tbl[(fetch_cnt - 1) & 511][63:32]);
        el = (req_left < rl) ? req_left : rl;
        if (chunk_addr != rgn_addr_of(fetch_cnt - 1)) seg_err++;
        if ({3'b0, chunk_len} != el) seg_err++;
        req_left  = req_left - {3'b0, chunk_len};
        bytes_sum = bytes_sum + {3'b0, chunk_len};
        seg_cnt++;
      end
    end
  end

  // watchdog
  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc == 150000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        summary();
      end
    end
  end

  task automatic load_table(input vec_t v);
    for (int i = 0; i < 512; i++) begin
      logic [31:0] sz;
      sz = (i < int'(v.ndesc)) ? v.size : 32'h0000_0004;
      if (v.lastmark && i == int'(v.ndesc) - 1) sz = sz | 32'h8000_0000;
      desc_tbl[i] = {sz, rgn_addr_of(i)};
    end
  endtask

  task automatic kick(input logic [31:0] base, input logic [19:0] req);
    @(negedge clk);
    tb_base   = base;
    fetch_cnt = 0;
    fetch_err = 0;
    seg_err   = 0;
    seg_cnt   = 0;
    req_left  = req;
    bytes_sum = '0;
    start     = 1'b1;
    tbl_base  = base;
    req_bytes = req;
    @(negedge clk);
    start     = 1'b0;
  endtask

  task automatic wait_done(output logic ok_seen);
    ok_seen = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      if (done) begin
        ok_seen = done_ok;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic verify(input vec_t v, input logic ok_seen, input string tag);
    check(ok_seen == v.exp_ok, {tag, " R8 done_ok"}, ok_seen, v.exp_ok);
    check(fetch_cnt == int'(v.exp_fetch), {tag, " R4/R6 fetch count"}, fetch_cnt, v.exp_fetch);
    check(bytes_sum == v.exp_bytes, {tag, " R6 byte total"}, bytes_sum, v.exp_bytes);
    check(seg_err == 0, {tag, " R2/R3 segment addr/len"}, seg_err, 0);
    check(fetch_err == 0, {tag, " R5 fetch address"}, fetch_err, 0);
  endtask

  initial begin
    logic ok_seen;
    finished   = 1'b0;
    n_checks   = 0;
    n_fail     = 0;
    stall_mode = 1'b0;
    start      = 1'b0;
    tbl_base   = '0;
    req_bytes  = '0;
    tb_base    = '0;
    fetch_cnt  = 0;
    fetch_err  = 0;
    seg_err    = 0;
    seg_cnt    = 0;
    req_left   = '0;
    bytes_sum  = '0;
    rst_n      = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state, during reset
    check(!busy && !done && !mem_req_valid && !chunk_valid, "R1 in reset",
          {busy, done, mem_req_valid, chunk_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req_valid && !chunk_valid, "R1 after reset",
          {busy, done, mem_req_valid, chunk_valid}, 0);

    for (int n = 0; n < NV; n++) begin
      vec_t v;
      v = VECS[n];
      load_table(v);
      stall_mode = v.stall;
      kick(32'h0000_8000 + 32'(n) * 32'h2000, v.req);
      wait_done(ok_seen);
      verify(v, ok_seen, $sformatf("vec%0d", n));
      stall_mode = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R11 zero request emits no segment
    check(seg_cnt == 0, "R11 no segment", seg_cnt, 0);

    // R10 start while busy is ignored
    begin
      vec_t v;
      v = VECS[1];
      load_table(v);
      kick(32'h0003_0000, v.req);
      repeat (2) @(negedge clk);
      check(busy == 1'b1, "R10 busy mid-run", busy, 1);
      start     = 1'b1;
      tbl_base  = 32'h0005_0000;
      req_bytes = 20'd5;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok_seen);
      verify(v, ok_seen, "R10 restart ignored");
      @(negedge clk);
      check(!done && !busy, "R8 done one cycle", {done, busy}, 0);
    end

    repeat (3) @(negedge clk);
    summary();
  end
endmodule